// File: doc/BRIEF.md
# SIMD Instruction Fault Classifier

This block decides, before a 128-bit packed-integer instruction executes, which fault that instruction raises, if any. Each request supplies a snapshot of the relevant machine state: whether the vector extension is present, the emulation, task-switched and OS save/restore control bits, the misaligned-access mode, the alignment-check enable, and the current operating mode. For instructions that touch memory it also supplies flags that describe the memory operand: a segment limit violation, a non-canonical address, a null segment, whether the access goes through the stack segment, and whether the page walk faulted. The low bits of the effective address decide 16-byte alignment.

A request is accepted in any cycle where `reqValid` is high. One cycle later `done` pulses for one cycle. In that cycle `faultVec` holds a one-hot code for the highest-priority fault and `faultValid` shows that a fault was found. The limit checks, the page walk and the delivery of the fault happen elsewhere. This block only combines their outcome flags under the mode and control gating and picks the fault by priority.

Top module: `simd_fault_classifier`

## Requirements
- R1: While `rstN` is low, and in the first cycle after release, `done`, `faultValid` and `faultVec` are all 0.
- R2: A request sampled with `reqValid`=1 at a clock edge makes `done` 1 for exactly the following cycle. A cycle that follows an edge with `reqValid`=0 has `done`=0, `faultValid`=0 and `faultVec`=0.
- R3: The invalid-opcode fault (`faultVec` bit 0) is raised in every mode when `featureOk`=0, when `emuBit`=1, or when `osSaveOk`=0.
- R4: The device-not-available fault (`faultVec` bit 1) is raised in every mode when `taskSwitched`=1.
- R5: With a memory operand, an access through the stack segment (`stackSeg`=1) that has `limitViol`=1 or `nonCanon`=1 raises the stack fault (`faultVec` bit 2) in every mode.
- R6: With a memory operand, `limitViol`=1 or `nonCanon`=1 on an access that is not through the stack segment raises the general-protection fault (`faultVec` bit 3) in every mode. `nullSeg`=1 raises it only in protected mode. `cpuMode` is encoded as 0 real, 1 virtual-8086 and 2 protected; code 3 is handled as protected.
- R7: With a memory operand whose `addrOffset` is nonzero (not 16-byte aligned) and `misalignMode`=0, the general-protection fault (bit 3) is raised in real and protected mode and not in virtual-8086 mode.
- R8: With a memory operand whose `addrOffset` is nonzero, `misalignMode`=1 and `alignChkEn`=1, the alignment-check fault (`faultVec` bit 5) is raised in virtual-8086 and protected mode and not in real mode. If `alignChkEn`=0, or if the operand is aligned, no fault is raised.
- R9: With a memory operand, `pageFault`=1 raises the page fault (`faultVec` bit 4) in virtual-8086 and protected mode and not in real mode.
- R10: Only the highest-priority fault is reported, in this order from highest to lowest: bit 0, bit 1, bit 2, bit 3, bit 4, bit 5. `faultVec` is never more than one-hot, and `faultValid` is 1 exactly when `faultVec` is nonzero.
- R11: When `memOp`=0, all memory flags and `addrOffset` are ignored, and only bits 0 and 1 can be raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Classify the instruction presented this cycle |
| featureOk | input | 1 | The vector extension is present |
| emuBit | input | 1 | Emulation control bit |
| taskSwitched | input | 1 | Task-switched control bit |
| osSaveOk | input | 1 | The OS supports vector state save/restore |
| misalignMode | input | 1 | Misaligned vector accesses are allowed (deferred to alignment check) |
| alignChkEn | input | 1 | Alignment checking is enabled |
| cpuMode | input | 2 | Operating mode: 0 real, 1 virtual-8086, 2 protected, 3 as protected |
| memOp | input | 1 | The instruction has a memory operand |
| addrOffset | input | ALIGN_LSB (4) | Low bits of the effective address |
| limitViol | input | 1 | Segment limit exceeded |
| nonCanon | input | 1 | Address is non-canonical |
| nullSeg | input | 1 | A null data segment is used |
| stackSeg | input | 1 | The access goes through the stack segment |
| pageFault | input | 1 | The page walk reported a fault |
| done | output | 1 | One-cycle pulse: the result is valid |
| faultValid | output | 1 | A fault was found |
| faultVec | output | 6 | One-hot fault code (bit 0 invalid opcode ... bit 5 alignment check) |

## Verification
The assertions assume that every input is a known value at each edge where `reqValid` is high. They also assume the instruction snapshot is stable only for that edge: nothing is remembered between requests, so the next request can change any field. The stimulus holds every snapshot input at a clean, fault-free default and changes only the flags a scenario needs. It drives all inputs at the falling edge, so every sampled value is settled. `cpuMode` code 3 is never driven, so every check stays within the three defined modes.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

  localparam int NUM_FAULTS = 6;

  // Fault bit positions, in priority order (lower index wins)
  localparam int F_UNDEF  = 0;
  localparam int F_NODEV  = 1;
  localparam int F_STACK  = 2;
  localparam int F_GPROT  = 3;
  localparam int F_PAGE   = 4;
  localparam int F_ALIGN  = 5;

  typedef enum logic [1:0] {
    MODE_REAL = 2'd0,
    MODE_V86  = 2'd1,
    MODE_PROT = 2'd2,
    MODE_RSVD = 2'd3
  } cpu_mode_e;

  typedef struct packed {
    logic capture;
    logic clear;
  } fault_ctl_t;

endpackage

// File: rtl/sfc_ctrl.sv
module sfc_ctrl
  import sfc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  output fault_ctl_t ctl,
  output logic       done
);

  logic doneQ;

  always_comb begin
    ctl.capture = reqValid;
    ctl.clear   = ~reqValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) doneQ <= 1'b0;
    else       doneQ <= reqValid;
  end

  assign done = doneQ;

  // R2
  req_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> done);

  // R2
  idle_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !done);

endmodule

// File: rtl/sfc_datapath.sv
module sfc_datapath
  import sfc_pkg::*;
#(
  parameter int ALIGN_LSB = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  fault_ctl_t            ctl,
  input  logic                  featureOk,
  input  logic                  emuBit,
  input  logic                  taskSwitched,
  input  logic                  osSaveOk,
  input  logic                  misalignMode,
  input  logic                  alignChkEn,
  input  logic [1:0]            cpuMode,
  input  logic                  memOp,
  input  logic [ALIGN_LSB-1:0]  addrOffset,
  input  logic                  limitViol,
  input  logic                  nonCanon,
  input  logic                  nullSeg,
  input  logic                  stackSeg,
  input  logic                  pageFault,
  output logic [NUM_FAULTS-1:0] faultVec,
  output logic                  faultValid
);

  cpu_mode_e mode;
  logic isReal, isV86, isProt;
  logic misaligned, badAddr;
  logic [NUM_FAULTS-1:0] rawFaults;
  logic [NUM_FAULTS-1:0] picked;
  logic [NUM_FAULTS-1:0] faultVecQ;

  always_comb begin
    mode       = cpu_mode_e'(cpuMode);
    isReal     = (mode == MODE_REAL);
    isV86      = (mode == MODE_V86);
    isProt     = (mode == MODE_PROT) || (mode == MODE_RSVD);
    misaligned = |addrOffset;
    badAddr    = limitViol | nonCanon;
  end

  // Raw fault conditions, each gated by mode and memory presence
  always_comb begin
    rawFaults          = '0;
    rawFaults[F_UNDEF] = ~featureOk | emuBit | ~osSaveOk;
    rawFaults[F_NODEV] = taskSwitched;
    rawFaults[F_STACK] = memOp & stackSeg & badAddr;
    rawFaults[F_GPROT] = memOp & ((~stackSeg & badAddr)
                                | (nullSeg & isProt)
                                | (misaligned & ~misalignMode & (isReal | isProt)));
    rawFaults[F_PAGE]  = memOp & pageFault & (isV86 | isProt);
    rawFaults[F_ALIGN] = memOp & misaligned & misalignMode & alignChkEn
                       & (isV86 | isProt);
  end

  // Fixed priority: lowest set index wins
  always_comb begin
    picked = '0;
    for (int i = NUM_FAULTS - 1; i >= 0; i--) begin
      if (rawFaults[i]) picked = NUM_FAULTS'(1) << i;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            faultVecQ <= '0;
    else if (ctl.capture) faultVecQ <= picked;
    else if (ctl.clear)   faultVecQ <= '0;
  end

  assign faultVec   = faultVecQ;
  assign faultValid = |faultVecQ;

  // R10
  onehot_vec_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(faultVec));

  // R3
  undef_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.capture && !featureOk) |=> faultVec[F_UNDEF]);

  // R4
  nodev_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.capture && taskSwitched && featureOk && !emuBit && osSaveOk)
      |=> faultVec[F_NODEV]);

  // R11
  nomem_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.capture && !memOp) |=> (faultVec[NUM_FAULTS-1:F_STACK] == '0));

  // R9
  real_no_page_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.capture && cpuMode == MODE_REAL) |=> !faultVec[F_PAGE] && !faultVec[F_ALIGN]);

endmodule

// File: rtl/simd_fault_classifier.sv
module simd_fault_classifier
  import sfc_pkg::*;
#(
  parameter int ALIGN_BYTES = 16,
  localparam int ALIGN_LSB  = $clog2(ALIGN_BYTES)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  input  logic                  featureOk,
  input  logic                  emuBit,
  input  logic                  taskSwitched,
  input  logic                  osSaveOk,
  input  logic                  misalignMode,
  input  logic                  alignChkEn,
  input  logic [1:0]            cpuMode,
  input  logic                  memOp,
  input  logic [ALIGN_LSB-1:0]  addrOffset,
  input  logic                  limitViol,
  input  logic                  nonCanon,
  input  logic                  nullSeg,
  input  logic                  stackSeg,
  input  logic                  pageFault,
  output logic                  done,
  output logic                  faultValid,
  output logic [NUM_FAULTS-1:0] faultVec
);

  fault_ctl_t ctl;

  sfc_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .ctl      (ctl),
    .done     (done)
  );

  sfc_datapath #(.ALIGN_LSB(ALIGN_LSB)) uData (
    .clk          (clk),
    .rstN         (rstN),
    .ctl          (ctl),
    .featureOk    (featureOk),
    .emuBit       (emuBit),
    .taskSwitched (taskSwitched),
    .osSaveOk     (osSaveOk),
    .misalignMode (misalignMode),
    .alignChkEn   (alignChkEn),
    .cpuMode      (cpuMode),
    .memOp        (memOp),
    .addrOffset   (addrOffset),
    .limitViol    (limitViol),
    .nonCanon     (nonCanon),
    .nullSeg      (nullSeg),
    .stackSeg     (stackSeg),
    .pageFault    (pageFault),
    .faultVec     (faultVec),
    .faultValid   (faultValid)
  );

  // R2
  valid_needs_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    faultValid |-> done);

endmodule

// File: tb/tb_simd_fault_classifier.sv
`timescale 1ns/1ps
module tb_simd_fault_classifier;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic featureOk, emuBit, taskSwitched, osSaveOk, misalignMode, alignChkEn;
  logic [1:0] cpuMode;
  logic memOp;
  logic [3:0] addrOffset;
  logic limitViol, nonCanon, nullSeg, stackSeg, pageFault;
  logic done, faultValid;
  logic [5:0] faultVec;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  simd_fault_classifier dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .featureOk(featureOk), .emuBit(emuBit), .taskSwitched(taskSwitched),
    .osSaveOk(osSaveOk), .misalignMode(misalignMode), .alignChkEn(alignChkEn),
    .cpuMode(cpuMode), .memOp(memOp), .addrOffset(addrOffset),
    .limitViol(limitViol), .nonCanon(nonCanon), .nullSeg(nullSeg),
    .stackSeg(stackSeg), .pageFault(pageFault),
    .done(done), .faultValid(faultValid), .faultVec(faultVec)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Clean snapshot: protected mode, no fault sources
  task automatic setClean();
    featureOk = 1; emuBit = 0; taskSwitched = 0; osSaveOk = 1;
    misalignMode = 0; alignChkEn = 0; cpuMode = 2'd2;
    memOp = 0; addrOffset = 4'h0;
    limitViol = 0; nonCanon = 0; nullSeg = 0; stackSeg = 0; pageFault = 0;
  endtask

  // Issue one request at a falling edge, check the result one cycle later
  task automatic issue(input logic [5:0] expVec, input string tag);
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    check({tag, " done"}, 32'(done), 32'd1);
    check({tag, " vec"}, 32'(faultVec), 32'(expVec));
    check({tag, " valid"}, 32'(faultValid), 32'(expVec != 6'd0));
    @(negedge clk);
    check({tag, " done drop R2"}, 32'(done), 32'd0);
    check({tag, " vec clear R2"}, 32'(faultVec), 32'd0);
  endtask

  task automatic test_reset();
    check("R1 done in reset", 32'(done), 32'd0);
    check("R1 valid in reset", 32'(faultValid), 32'd0);
    check("R1 vec in reset", 32'(faultVec), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 done after release", 32'(done), 32'd0);
    check("R1 vec after release", 32'(faultVec), 32'd0);
  endtask

  task automatic test_idle();
    setClean(); featureOk = 0; taskSwitched = 1;
    @(negedge clk);
    check("R2 idle no done", 32'(done), 32'd0);
    check("R2 idle no vec", 32'(faultVec), 32'd0);
    setClean();
    issue(6'h00, "R2 clean request");
    memOp = 1; addrOffset = 4'h0;
    issue(6'h00, "R2 clean aligned memory");
  endtask

  task automatic test_undef();
    setClean(); featureOk = 0; issue(6'h01, "R3 no feature");
    setClean(); emuBit = 1; issue(6'h01, "R3 emulate set");
    setClean(); osSaveOk = 0; cpuMode = 2'd0; issue(6'h01, "R3 no os support real");
    setClean(); featureOk = 0; cpuMode = 2'd1; issue(6'h01, "R3 no feature v86");
  endtask

  task automatic test_nodev();
    setClean(); taskSwitched = 1; issue(6'h02, "R4 task switched");
    setClean(); taskSwitched = 1; cpuMode = 2'd0; issue(6'h02, "R4 task switched real");
  endtask

  task automatic test_stack();
    setClean(); memOp = 1; stackSeg = 1; limitViol = 1; issue(6'h04, "R5 stack limit");
    setClean(); memOp = 1; stackSeg = 1; nonCanon = 1; cpuMode = 2'd0;
    issue(6'h04, "R5 stack noncanon real");
  endtask

  task automatic test_gp_seg();
    setClean(); memOp = 1; limitViol = 1; cpuMode = 2'd1; issue(6'h08, "R6 data limit v86");
    setClean(); memOp = 1; nonCanon = 1; issue(6'h08, "R6 data noncanon");
    setClean(); memOp = 1; nullSeg = 1; issue(6'h08, "R6 null seg protected");
    setClean(); memOp = 1; nullSeg = 1; cpuMode = 2'd1; issue(6'h00, "R6 null seg v86");
    setClean(); memOp = 1; nullSeg = 1; cpuMode = 2'd0; issue(6'h00, "R6 null seg real");
  endtask

  task automatic test_misalign_gp();
    setClean(); memOp = 1; addrOffset = 4'h4; issue(6'h08, "R7 misaligned protected");
    setClean(); memOp = 1; addrOffset = 4'h1; cpuMode = 2'd0; issue(6'h08, "R7 misaligned real");
    setClean(); memOp = 1; addrOffset = 4'h8; cpuMode = 2'd1; issue(6'h00, "R7 misaligned v86");
    setClean(); memOp = 1; addrOffset = 4'h8; misalignMode = 1; issue(6'h00, "R7 mode set no gp");
  endtask

  task automatic test_align_chk();
    setClean(); memOp = 1; addrOffset = 4'h2; misalignMode = 1; alignChkEn = 1;
    issue(6'h20, "R8 ac protected");
    cpuMode = 2'd1; issue(6'h20, "R8 ac v86");
    cpuMode = 2'd0; issue(6'h00, "R8 ac real");
    cpuMode = 2'd2; alignChkEn = 0; issue(6'h00, "R8 ac disabled");
    alignChkEn = 1; addrOffset = 4'h0; issue(6'h00, "R8 ac aligned");
  endtask

  task automatic test_page();
    setClean(); memOp = 1; pageFault = 1; issue(6'h10, "R9 page protected");
    cpuMode = 2'd1; issue(6'h10, "R9 page v86");
    cpuMode = 2'd0; issue(6'h00, "R9 page real");
  endtask

  task automatic test_priority();
    setClean(); taskSwitched = 1; emuBit = 1; issue(6'h01, "R10 undef over nodev");
    setClean(); taskSwitched = 1; memOp = 1; stackSeg = 1; limitViol = 1; pageFault = 1;
    issue(6'h02, "R10 nodev over memory");
    setClean(); memOp = 1; stackSeg = 1; limitViol = 1; nullSeg = 1;
    issue(6'h04, "R10 stack over gp");
    setClean(); memOp = 1; nullSeg = 1; pageFault = 1; issue(6'h08, "R10 gp over page");
    setClean(); memOp = 1; pageFault = 1; addrOffset = 4'h3; misalignMode = 1; alignChkEn = 1;
    issue(6'h10, "R10 page over ac");
  endtask

  task automatic test_nomem();
    setClean(); memOp = 0; stackSeg = 1; limitViol = 1; nonCanon = 1; nullSeg = 1;
    pageFault = 1; addrOffset = 4'hF; alignChkEn = 1;
    issue(6'h00, "R11 no memory operand");
    taskSwitched = 1; issue(6'h02, "R11 no memory keeps nodev");
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    setClean();
    @(negedge clk);
    @(negedge clk);
    test_reset();
    test_idle();
    test_undef();
    test_nodev();
    test_stack();
    test_gp_seg();
    test_misalign_gp();
    test_align_chk();
    test_page();
    test_priority();
    test_nomem();
    finish_run();
  end

endmodule